// File: doc/BRIEF.md
# Alternating Read/Write Start Scheduler

This block sits in front of a two-port memory whose read side and write side each need two clock cycles per access. On every rising clock edge it samples an active-low read select and an active-low write select, together with a separate read address and write address. For each sampled cycle it decides to start a read, to start a write or to do nothing. It then emits a one-cycle start pulse for the chosen port and the address of that port.

The decision depends only on what the previous decision started. A port that started an access in the previous cycle cannot start again, and its request in that cycle is dropped without notice. When both selects are active, the port that did not run last wins, and the read side wins from idle. Holding both selects active therefore gives a strict read/write alternation. A dropped request is not remembered. The requester must present it again.

Top module: `dual_port_alt_sched`

## Requirements
- R1: While rst_ni is low, both start outputs and addr_o are 0. The first decision after reset behaves as if the previous cycle started nothing.
- R2: A select is active when low. The decision for the inputs sampled at rising edge N appears on the outputs after rising edge N+1 and lasts one cycle.
- R3: A lone read request with no read started in the previous decision gives start_rd_o=1 and start_wr_o=0. In that cycle addr_o equals the read address sampled with it.
- R4: A lone write request with no write started in the previous decision gives start_wr_o=1 and start_rd_o=0. In that cycle addr_o equals the write address sampled with it.
- R5: A read request in the cycle right after a read was started is dropped, and start_rd_o stays 0 for it.
- R6: A write request in the cycle right after a write was started is dropped, and start_wr_o stays 0 for it.
- R7: If both selects are active and the previous decision started nothing, a read is started.
- R8: If both selects are active and the previous decision started a read, a write is started.
- R9: If both selects are active and the previous decision started a write, a read is started.
- R10: Both selects held active from idle give starts in the order read, write, read, write, with no empty cycle between them.
- R11: start_rd_o and start_wr_o are never 1 in the same cycle.
- R12: A dropped request is not queued. If the selects go inactive afterwards, no start follows for it. When neither start output is 1, addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling happens on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read request, active low |
| wr_sel_ni | input | 1 | Write request, active low |
| rd_addr_i | input | ADDR_W | Address for a read request |
| wr_addr_i | input | ADDR_W | Address for a write request |
| start_rd_o | output | 1 | One-cycle pulse that starts a read |
| start_wr_o | output | 1 | One-cycle pulse that starts a write |
| addr_o | output | ADDR_W | Address of the started access, 0 when nothing starts |

## Verification
Each decision passes through two registers: the input sampling stage and the output stage. Its result is therefore due one full cycle after the edge that samples the request. The bench drives its inputs on falling edges and keeps a two-deep list of expected results. At every falling edge it compares the outputs against the entry driven two falling edges earlier. This means every cycle is checked, including the empty ones between a request and its start. The checker relates each start to the selects two samples back and to the start outputs one sample back.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/sched_in_stage.sv
module sched_in_stage #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_o  <= 1'b0;
      wr_req_o  <= 1'b0;
      rd_addr_o <= '0;
      wr_addr_o <= '0;
    end else begin
      rd_req_o  <= ~rd_sel_ni;
      wr_req_o  <= ~wr_sel_ni;
      rd_addr_o <= rd_addr_i;
      wr_addr_o <= wr_addr_i;
    end
  end
endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
  import sched_pkg::*;
(
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  acc_e prev_i,
  output acc_e grant_o
);
  logic rd_ok, wr_ok;

  // a port that ran last cycle is blocked; read wins otherwise
  assign rd_ok = rd_req_i && (prev_i != ACC_RD);
  assign wr_ok = wr_req_i && (prev_i != ACC_WR);

  always_comb begin
    if (rd_ok)      grant_o = ACC_RD;
    else if (wr_ok) grant_o = ACC_WR;
    else            grant_o = ACC_NONE;
  end
endmodule

// File: rtl/sched_out_stage.sv
module sched_out_stage
  import sched_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              grant_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output acc_e              prev_o,
  output logic              start_rd_o,
  output logic              start_wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (grant_i)
      ACC_RD:  addr_d = rd_addr_i;
      ACC_WR:  addr_d = wr_addr_i;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o     <= ACC_NONE;
      start_rd_o <= 1'b0;
      start_wr_o <= 1'b0;
      addr_o     <= '0;
    end else begin
      prev_o     <= grant_i;
      start_rd_o <= (grant_i == ACC_RD);
      start_wr_o <= (grant_i == ACC_WR);
      addr_o     <= addr_d;
    end
  end
endmodule

// File: rtl/dual_port_alt_sched.sv
module dual_port_alt_sched
  import sched_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              start_rd_o,
  output logic              start_wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              rd_req, wr_req;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  acc_e              grant, prev;

  sched_in_stage #(.ADDR_W(ADDR_W)) in_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_sel_ni (rd_sel_ni),
    .wr_sel_ni (wr_sel_ni),
    .rd_addr_i (rd_addr_i),
    .wr_addr_i (wr_addr_i),
    .rd_req_o  (rd_req),
    .wr_req_o  (wr_req),
    .rd_addr_o (rd_addr_q),
    .wr_addr_o (wr_addr_q)
  );

  sched_arbiter arb_i (
    .rd_req_i (rd_req),
    .wr_req_i (wr_req),
    .prev_i   (prev),
    .grant_o  (grant)
  );

  sched_out_stage #(.ADDR_W(ADDR_W)) out_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .rd_addr_i  (rd_addr_q),
    .wr_addr_i  (wr_addr_q),
    .prev_o     (prev),
    .start_rd_o (start_rd_o),
    .start_wr_o (start_wr_o),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/dual_port_alt_sched_chk.sv
module dual_port_alt_sched_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_sel_ni,
  input logic              wr_sel_ni,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              start_rd_o,
  input logic              start_wr_o,
  input logic [ADDR_W-1:0] addr_o
);
  // R11
  one_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_rd_o, start_wr_o}));

  // R5
  no_rd_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_o |=> !start_rd_o);

  // R6
  no_wr_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_o |=> !start_wr_o);

  // R2
  rd_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_o |-> !$past(rd_sel_ni, 2));

  // R2
  wr_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_o |-> !$past(wr_sel_ni, 2));

  // R3
  rd_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_o |-> addr_o == $past(rd_addr_i, 2));

  // R4
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_o |-> addr_o == $past(wr_addr_i, 2));

  // R8
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_rd_o) && !$past(wr_sel_ni, 2)) |-> start_wr_o);

  // R9
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_wr_o) && !$past(rd_sel_ni, 2)) |-> start_rd_o);

  // R12
  idle_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_rd_o && !start_wr_o) |-> addr_o == '0);
endmodule

bind dual_port_alt_sched dual_port_alt_sched_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dual_port_alt_sched_tb_top.sv
module dual_port_alt_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int K_NONE = 0;
  localparam int K_RD = 1;
  localparam int K_WR = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_sel_ni = 1'b1;
  logic          wr_sel_ni = 1'b1;
  logic [AW-1:0] rd_addr_i = '0;
  logic [AW-1:0] wr_addr_i = '0;
  logic          start_rd_o, start_wr_o;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int q1_k = K_NONE, q2_k = K_NONE;
  logic [AW-1:0] q1_a = '0, q2_a = '0;
  string q1_t = "R1", q2_t = "R1";

  dual_port_alt_sched #(.ADDR_W(AW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_sel_ni  (rd_sel_ni),
    .wr_sel_ni  (wr_sel_ni),
    .rd_addr_i  (rd_addr_i),
    .wr_addr_i  (wr_addr_i),
    .start_rd_o (start_rd_o),
    .start_wr_o (start_wr_o),
    .addr_o     (addr_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string tag, int exp_k, logic [AW-1:0] exp_a);
    int act_k;
    act_k = (start_rd_o ? K_RD : 0) + (start_wr_o ? K_WR : 0);
    checks++;
    if (act_k != exp_k || addr_o !== exp_a) begin
      errors++;
      $display("FAIL %s: kind=%0d addr=%h expected kind=%0d addr=%h",
               tag, act_k, addr_o, exp_k, exp_a);
    end
  endtask

  // one cycle: check entry from two cycles ago, then drive a new request
  task automatic cyc(bit rd, bit wr, logic [AW-1:0] ra, logic [AW-1:0] wa,
                     int exp_k, string tag);
    @(negedge clk_i);
    check(q2_t, q2_k, q2_a);
    q2_k = q1_k; q2_a = q1_a; q2_t = q1_t;
    q1_k = exp_k;
    q1_a = (exp_k == K_RD) ? ra : (exp_k == K_WR) ? wa : '0;
    q1_t = tag;
    rd_sel_ni = ~rd; wr_sel_ni = ~wr;
    rd_addr_i = ra;  wr_addr_i = wa;
  endtask

  task automatic idle2(string tag);
    cyc(0, 0, 20'h0, 20'h0, K_NONE, tag);
    cyc(0, 0, 20'h0, 20'h0, K_NONE, tag);
  endtask

  task automatic t_reset();
    rd_sel_ni = 1'b0; wr_sel_ni = 1'b0;
    rd_addr_i = 20'h11111; wr_addr_i = 20'h22222;
    repeat (3) @(negedge clk_i);
    check("R1", K_NONE, '0);
    rd_sel_ni = 1'b1; wr_sel_ni = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle2("R1");
  endtask

  task automatic t_single_read();
    cyc(1, 0, 20'h0A5A5, 20'h00001, K_RD, "R3");
    idle2("R2");
  endtask

  task automatic t_single_write();
    cyc(0, 1, 20'h00002, 20'hF0F0F, K_WR, "R4");
    idle2("R2");
  endtask

  task automatic t_read_pair();
    cyc(1, 0, 20'h00100, 20'h0, K_RD, "R3");
    cyc(1, 0, 20'h00200, 20'h0, K_NONE, "R5");
    cyc(1, 0, 20'h00300, 20'h0, K_RD, "R5");
    idle2("R5");
  endtask

  task automatic t_write_pair();
    cyc(0, 1, 20'h0, 20'h00400, K_WR, "R4");
    cyc(0, 1, 20'h0, 20'h00500, K_NONE, "R6");
    cyc(0, 1, 20'h0, 20'h00600, K_WR, "R6");
    idle2("R6");
  endtask

  task automatic t_both_from_idle();
    cyc(1, 1, 20'h01234, 20'h05678, K_RD, "R7");
    idle2("R7");
  endtask

  task automatic t_alternate();
    cyc(1, 1, 20'h10001, 20'h20001, K_RD, "R10");
    cyc(1, 1, 20'h10002, 20'h20002, K_WR, "R10");
    cyc(1, 1, 20'h10003, 20'h20003, K_RD, "R10");
    cyc(1, 1, 20'h10004, 20'h20004, K_WR, "R10");
    idle2("R10");
  endtask

  task automatic t_after_read();
    cyc(1, 0, 20'h30001, 20'h0, K_RD, "R3");
    cyc(1, 1, 20'h30002, 20'h40002, K_WR, "R8");
    idle2("R8");
  endtask

  task automatic t_after_write();
    cyc(0, 1, 20'h0, 20'h50001, K_WR, "R4");
    cyc(1, 1, 20'h60002, 20'h50002, K_RD, "R9");
    cyc(1, 1, 20'h60003, 20'h50003, K_WR, "R8");
    idle2("R9");
  endtask

  task automatic t_not_queued();
    cyc(1, 0, 20'h70001, 20'h0, K_RD, "R3");
    cyc(1, 0, 20'h70002, 20'h0, K_NONE, "R5");
    cyc(0, 0, 20'h0, 20'h0, K_NONE, "R12");
    cyc(0, 0, 20'h0, 20'h0, K_NONE, "R12");
    cyc(0, 1, 20'h0, 20'h80001, K_WR, "R4");
    cyc(0, 1, 20'h0, 20'h80002, K_NONE, "R6");
    cyc(0, 0, 20'h0, 20'h0, K_NONE, "R12");
    idle2("R12");
  endtask

  task automatic t_onehot();
    cyc(1, 1, 20'h90001, 20'hA0001, K_RD, "R11");
    cyc(0, 1, 20'h90002, 20'hA0002, K_WR, "R11");
    cyc(1, 0, 20'h90003, 20'hA0003, K_RD, "R11");
    idle2("R11");
  endtask

  initial begin
    t_reset();
    t_single_read();
    t_single_write();
    t_read_pair();
    t_write_pair();
    t_both_from_idle();
    t_alternate();
    t_after_read();
    t_after_write();
    t_not_queued();
    t_onehot();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule